// File: doc/BRIEF.md
# Framebuffer Display Scan-Out Controller

This block turns a region of memory into a live picture on a TFT or VGA panel. It runs a raster of 640 visible pixels by 480 visible lines inside an 800-clock line and a 525-line frame. For every visible pixel it fetches one 32-bit word from memory through a valid/ready read port with fixed return latency. It takes the colour channels out of that word and presents them with the data-enable and the active-low sync strobes. A small prefetch queue keeps the fetches ahead of the pixels being shown.

Software sees two registers on a simple synchronous port. Register 0 sets where the image lives. Only the top 11 bits of the 32-bit byte address are kept, so an image always starts on a 2 MiB boundary. Register 1 has two bits: one turns the picture on, the other turns it upside down. In memory every line takes 1024 words, and only the first 640 of them are ever read. The base address, rotate bit and enable bit are copied into the scan engine once per frame, just before the first visible line. A frame is therefore always drawn with a single setting. While the picture is off, the syncs keep running, the colour outputs stay black and no memory reads are made.

Top module: `fbscan_ctrl`

## Requirements
- R1: While reset is asserted, pix_de is 0, both sync outputs are 1, the colour outputs are 0 and mem_req_valid is 0. Both registers read back as 0.
- R2: A read of register 0 returns the stored base in bits 31:21 with bits 20:0 zero. A read of register 1 returns the enable bit in bit 0 and the rotate bit in bit 1, with every other bit zero. When register 0 is written, bits 20:0 of the write data are dropped.
- R3: pix_hsync_n is low for HSW clocks of every H_TOT-clock line. pix_vsync_n is low for VSW whole lines of every V_TOT-line frame. Over one frame of H_TOT*V_TOT clocks there are exactly V_TOT*HSW hsync-low clocks and VSW*H_TOT vsync-low clocks, and no hsync-low run is longer than HSW.
- R4: pix_de is high for H_ACT clocks on each of V_ACT lines per frame. Whenever pix_de is low, the colour outputs are 0.
- R5: With rotation off, pixels are fetched and shown in row-major order from row 0, column 0. The byte address of row r, column c is base*2^21 + r*4096 + c*4, so bits 1:0 are zero and no column at or beyond H_ACT is ever requested.
- R6: Each fetched word maps red to bits 23:16, green to bits 15:8 and blue to bits 7:0. Bits 31:24 have no effect on the output.
- R7: With rotation on, the first pixel shown is row V_ACT-1, column H_ACT-1, and rows and columns both run backwards, so that display pixel (r,c) shows memory location (V_ACT-1-r, H_ACT-1-c).
- R8: In a frame that starts with enable clear, no memory request is made, the colour outputs are 0, and pix_de and both syncs keep their normal timing.
- R9: Writes to base, rotate and enable take effect at the next frame start only. A base write made partway through a frame leaves the rest of that frame drawn from the old base, and the following frame uses the new base.
- R10: A request held with mem_req_ready low keeps mem_req_valid high and mem_req_addr unchanged until it is accepted. Pictures stay pixel-exact when ready drops for single cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 1 | Register select: 0 base, 1 control |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data for reg_idx |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | ADDR_W | Byte address of requested word |
| mem_rdata | input | 32 | Read data, RD_LAT clocks after acceptance |
| pix_de | output | 1 | Visible-area data enable |
| pix_hsync_n | output | 1 | Horizontal sync, active low |
| pix_vsync_n | output | 1 | Vertical sync, active low |
| pix_red | output | 8 | Red channel |
| pix_green | output | 8 | Green channel |
| pix_blue | output | 8 | Blue channel |

## Verification
The memory model in the bench returns a word that encodes the row, the column and the low base bits it was fetched from. A wrong row or column count, a faulty mirror, or a stale base therefore shows up as a wrong colour on the very pixel where the fault starts, and stays wrong for the rest of that frame. A prefetch queue that falls out of step with the raster shows up as shifted or black pixels inside the first visible line of a frame. Settings taken in at the wrong moment show up as a frame drawn partly from each setting. A raster counter fault changes the per-frame totals of sync and enable clocks within one frame.

// File: rtl/fbscan_pkg.sv
package fbscan_pkg;

  localparam int CHAN_W = 8;

  typedef struct packed {
    logic [CHAN_W-1:0] red;
    logic [CHAN_W-1:0] green;
    logic [CHAN_W-1:0] blue;
  } rgb_t;

  // Colour channels sit in the low three bytes of a memory word.
  function automatic rgb_t word_to_rgb(input logic [3*CHAN_W-1:0] low_bytes);
    return rgb_t'(low_bytes);
  endfunction

endpackage

// File: rtl/fbscan_timing.sv
module fbscan_timing #(
  parameter int H_ACT = 640,
  parameter int HFP   = 16,
  parameter int HSW   = 96,
  parameter int HBP   = 48,
  parameter int V_ACT = 480,
  parameter int VFP   = 10,
  parameter int VSW   = 2,
  parameter int VBP   = 33
) (
  input  logic clk,
  input  logic rst_n,
  output logic active,
  output logic hsync_n,
  output logic vsync_n,
  output logic frame_tick
);
  localparam int H_TOT = H_ACT + HFP + HSW + HBP;
  localparam int V_TOT = V_ACT + VFP + VSW + VBP;
  localparam int HW    = $clog2(H_TOT);
  localparam int VW    = $clog2(V_TOT);

  logic [HW-1:0] h_q, h_d;
  logic [VW-1:0] v_q, v_d;
  logic          h_last, v_last;

  always_comb begin
    h_last = (h_q == HW'(H_TOT - 1));
    v_last = (v_q == VW'(V_TOT - 1));
    h_d    = h_last ? '0 : h_q + 1'b1;
    v_d    = v_q;
    if (h_last) v_d = v_last ? '0 : v_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= '0;
      v_q <= '0;
    end else begin
      h_q <= h_d;
      v_q <= v_d;
    end
  end

  assign active     = (h_q < HW'(H_ACT)) && (v_q < VW'(V_ACT));
  assign hsync_n    = !((h_q >= HW'(H_ACT + HFP)) && (h_q < HW'(H_ACT + HFP + HSW)));
  assign vsync_n    = !((v_q >= VW'(V_ACT + VFP)) && (v_q < VW'(V_ACT + VFP + VSW)));
  // Settings are taken at the start of the last blank line, ahead of row 0.
  assign frame_tick = v_last && (h_q == '0);

endmodule

// File: rtl/fbscan_fifo.sv
module fbscan_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [W-1:0]  store_q [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [LW-1:0] lvl_q, lvl_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    lvl_d = lvl_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      lvl_d = '0;
    end else begin
      if (push) wr_d = bump(wr_q);
      if (pop)  rd_d = bump(rd_q);
      lvl_d = lvl_q + LW'(push) - LW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) store_q[wr_q] <= din;
  end

  assign dout  = store_q[rd_q];
  assign level = lvl_q;
  assign empty = (lvl_q == '0);

endmodule

// File: rtl/fbscan_fetch.sv
module fbscan_fetch #(
  parameter int H_ACT       = 640,
  parameter int V_ACT       = 480,
  parameter int ADDR_W      = 32,
  parameter int BASE_W      = 11,
  parameter int STRIDE_LOG2 = 10,
  parameter int RD_LAT      = 4,
  parameter int DEPTH       = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       restart,
  input  logic                       en,
  input  logic                       rot,
  input  logic [BASE_W-1:0]          base,
  input  logic [$clog2(DEPTH+1)-1:0] fifo_level,
  output logic                       req_valid,
  input  logic                       req_ready,
  output logic [ADDR_W-1:0]          req_addr,
  output logic                       ret_valid
);
  localparam int ROW_W = ADDR_W - BASE_W - STRIDE_LOG2 - 2;
  localparam int FRW   = ROW_W + 1;
  localparam int LW    = $clog2(DEPTH + 1);
  localparam int SW    = LW + 1;

  logic [FRW-1:0]         row_q, row_d;
  logic [STRIDE_LOG2-1:0] col_q, col_d;
  logic [LW-1:0]          infl_q, infl_d;
  logic [RD_LAT-1:0]      pipe_q, pipe_d;
  logic                   done, room, fire;
  logic [ROW_W-1:0]       row_sel;
  logic [STRIDE_LOG2-1:0] col_sel;

  always_comb begin
    done      = (row_q >= FRW'(V_ACT));
    room      = (SW'(fifo_level) + SW'(infl_q)) < SW'(DEPTH);
    req_valid = en && !done && room;
    fire      = req_valid && req_ready;
    ret_valid = pipe_q[RD_LAT-1];
    row_sel   = rot ? ROW_W'(V_ACT - 1) - row_q[ROW_W-1:0] : row_q[ROW_W-1:0];
    col_sel   = rot ? STRIDE_LOG2'(H_ACT - 1) - col_q : col_q;
    req_addr  = {base, row_sel, col_sel, 2'b00};

    row_d  = row_q;
    col_d  = col_q;
    pipe_d = (pipe_q << 1) | RD_LAT'(fire);
    infl_d = infl_q + LW'(fire) - LW'(ret_valid);
    if (fire) begin
      if (col_q == STRIDE_LOG2'(H_ACT - 1)) begin
        col_d = '0;
        row_d = row_q + 1'b1;
      end else begin
        col_d = col_q + 1'b1;
      end
    end
    if (restart) begin
      row_d  = '0;
      col_d  = '0;
      pipe_d = '0;
      infl_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      col_q  <= '0;
      pipe_q <= '0;
      infl_q <= '0;
    end else begin
      row_q  <= row_d;
      col_q  <= col_d;
      pipe_q <= pipe_d;
      infl_q <= infl_d;
    end
  end

endmodule

// File: rtl/fbscan_ctrl.sv
module fbscan_ctrl
  import fbscan_pkg::*;
#(
  parameter int H_ACT       = 640,
  parameter int HFP         = 16,
  parameter int HSW         = 96,
  parameter int HBP         = 48,
  parameter int V_ACT       = 480,
  parameter int VFP         = 10,
  parameter int VSW         = 2,
  parameter int VBP         = 33,
  parameter int ADDR_W      = 32,
  parameter int BASE_W      = 11,
  parameter int STRIDE_LOG2 = 10,
  parameter int RD_LAT      = 4,
  parameter int FIFO_DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_idx,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic [31:0]       mem_rdata,
  output logic              pix_de,
  output logic              pix_hsync_n,
  output logic              pix_vsync_n,
  output logic [7:0]        pix_red,
  output logic [7:0]        pix_green,
  output logic [7:0]        pix_blue
);
  localparam int LW = $clog2(FIFO_DEPTH + 1);

  // Reset: asserted at once, released after two clock edges.
  logic rst_meta_q, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_n_s, rst_meta_q} <= 2'b00;
    else        {rst_n_s, rst_meta_q} <= {rst_meta_q, 1'b1};
  end

  // Software-visible registers and their per-frame copies.
  logic [BASE_W-1:0] base_q, base_d, cur_base_q, cur_base_d;
  logic [1:0]        ctl_q, ctl_d;
  logic              cur_en_q, cur_en_d, cur_rot_q, cur_rot_d;
  logic              active, hsync_n, vsync_n, frame_tick;
  logic              ret_valid, fifo_empty, pop;
  logic [LW-1:0]     fifo_level;
  rgb_t              fifo_dout, rgb_q, rgb_d;
  logic              de_q, de_d, hs_q, hs_d, vs_q, vs_d;
  logic              unused_bits;

  assign unused_bits = ^{mem_rdata[31:24], reg_wdata[ADDR_W-BASE_W-1:2]};

  always_comb begin
    base_d = base_q;
    ctl_d  = ctl_q;
    if (reg_we && !reg_idx) base_d = reg_wdata[ADDR_W-1 -: BASE_W];
    if (reg_we &&  reg_idx) ctl_d  = reg_wdata[1:0];
    cur_base_d = frame_tick ? base_q   : cur_base_q;
    cur_en_d   = frame_tick ? ctl_q[0] : cur_en_q;
    cur_rot_d  = frame_tick ? ctl_q[1] : cur_rot_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      base_q     <= '0;
      ctl_q      <= '0;
      cur_base_q <= '0;
      cur_en_q   <= 1'b0;
      cur_rot_q  <= 1'b0;
    end else begin
      base_q     <= base_d;
      ctl_q      <= ctl_d;
      cur_base_q <= cur_base_d;
      cur_en_q   <= cur_en_d;
      cur_rot_q  <= cur_rot_d;
    end
  end

  assign reg_rdata = reg_idx ? {{(ADDR_W-2){1'b0}}, ctl_q}
                             : {base_q, {(ADDR_W-BASE_W){1'b0}}};

  fbscan_timing #(
    .H_ACT(H_ACT), .HFP(HFP), .HSW(HSW), .HBP(HBP),
    .V_ACT(V_ACT), .VFP(VFP), .VSW(VSW), .VBP(VBP)
  ) u_timing (
    .clk(clk), .rst_n(rst_n_s), .active(active), .hsync_n(hsync_n),
    .vsync_n(vsync_n), .frame_tick(frame_tick)
  );

  fbscan_fetch #(
    .H_ACT(H_ACT), .V_ACT(V_ACT), .ADDR_W(ADDR_W), .BASE_W(BASE_W),
    .STRIDE_LOG2(STRIDE_LOG2), .RD_LAT(RD_LAT), .DEPTH(FIFO_DEPTH)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n_s), .restart(frame_tick), .en(cur_en_q),
    .rot(cur_rot_q), .base(cur_base_q), .fifo_level(fifo_level),
    .req_valid(mem_req_valid), .req_ready(mem_req_ready),
    .req_addr(mem_req_addr), .ret_valid(ret_valid)
  );

  fbscan_fifo #(.W($bits(rgb_t)), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n_s), .flush(frame_tick), .push(ret_valid),
    .din(word_to_rgb(mem_rdata[23:0])), .pop(pop), .dout(fifo_dout),
    .level(fifo_level), .empty(fifo_empty)
  );

  // Output stage: one register after the raster counters.
  always_comb begin
    pop  = active && cur_en_q && !fifo_empty;
    de_d = active;
    hs_d = hsync_n;
    vs_d = vsync_n;
    rgb_d = pop ? fifo_dout : '0;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      de_q  <= 1'b0;
      hs_q  <= 1'b1;
      vs_q  <= 1'b1;
      rgb_q <= '0;
    end else begin
      de_q  <= de_d;
      hs_q  <= hs_d;
      vs_q  <= vs_d;
      rgb_q <= rgb_d;
    end
  end

  assign pix_de      = de_q;
  assign pix_hsync_n = hs_q;
  assign pix_vsync_n = vs_q;
  assign pix_red     = rgb_q.red;
  assign pix_green   = rgb_q.green;
  assign pix_blue    = rgb_q.blue;

endmodule

// File: rtl/fbscan_ctrl_chk.sv
module fbscan_ctrl_chk #(
  parameter int H_ACT       = 640,
  parameter int ADDR_W      = 32,
  parameter int STRIDE_LOG2 = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pix_de,
  input logic              pix_vsync_n,
  input logic [7:0]        pix_red,
  input logic [7:0]        pix_green,
  input logic [7:0]        pix_blue,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              cur_en,
  input logic              frame_tick
);

  p_blank_black_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_de |-> ({pix_red, pix_green, pix_blue} == 24'h0));

  p_vsync_outside_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_vsync_n |-> !pix_de);

  p_req_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready && !frame_tick)
      |=> (mem_req_valid && $stable(mem_req_addr)));

  p_no_fetch_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_en |-> !mem_req_valid);

  p_visible_words_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> ((mem_req_addr[1:0] == 2'b00) &&
                       (int'(mem_req_addr[2 +: STRIDE_LOG2]) < H_ACT)));

endmodule

bind fbscan_ctrl fbscan_ctrl_chk #(
  .H_ACT(H_ACT), .ADDR_W(ADDR_W), .STRIDE_LOG2(STRIDE_LOG2)
) u_chk (
  .clk(clk), .rst_n(rst_n_s), .pix_de(pix_de), .pix_vsync_n(pix_vsync_n),
  .pix_red(pix_red), .pix_green(pix_green), .pix_blue(pix_blue),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .cur_en(cur_en_q), .frame_tick(frame_tick)
);

// File: tb/fbscan_ctrl_bench.sv
`timescale 1ns/1ps
module fbscan_ctrl_bench;
  localparam int H_ACT = 8, HFP = 2, HSW = 2, HBP = 2;
  localparam int V_ACT = 4, VFP = 1, VSW = 2, VBP = 1;
  localparam int H_TOT = H_ACT + HFP + HSW + HBP;
  localparam int V_TOT = V_ACT + VFP + VSW + VBP;
  localparam int FRAME = H_TOT * V_TOT;
  localparam int RD_LAT = 3;
  localparam int WD_CYC = 20000;

  // Vector: base[13:3], control[2:1] (bit1 rotate, bit0 enable), stall[0]
  localparam int NVEC = 6;
  localparam logic [13:0] VEC [NVEC] = '{
    {11'h001, 2'b01, 1'b0},
    {11'h2A5, 2'b11, 1'b0},
    {11'h7FF, 2'b01, 1'b1},
    {11'h155, 2'b11, 1'b1},
    {11'h0F0, 2'b10, 1'b0},
    {11'h3C3, 2'b01, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we, reg_idx;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr, mem_rdata;
  logic        pix_de, pix_hsync_n, pix_vsync_n;
  logic [7:0]  pix_red, pix_green, pix_blue;

  int tests = 0, fails = 0, cyc = 0;
  bit stall_on = 1'b0;
  logic [31:0] mp_addr [RD_LAT];

  always #10 clk = ~clk;

  fbscan_ctrl #(
    .H_ACT(H_ACT), .HFP(HFP), .HSW(HSW), .HBP(HBP),
    .V_ACT(V_ACT), .VFP(VFP), .VSW(VSW), .VBP(VBP),
    .RD_LAT(RD_LAT), .FIFO_DEPTH(8)
  ) u_fbscan_ctrl (.*);

  // Memory model: the word encodes where it came from; top byte is junk.
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {8'hEE, a[19:12] ^ 8'h30, a[9:2] ^ 8'h0C, a[28:21]};
  endfunction

  function automatic logic [23:0] exp_pix(input logic [10:0] b, input logic rot, input int p);
    int r = p / H_ACT;
    int c = p % H_ACT;
    if (rot) begin r = V_ACT - 1 - r; c = H_ACT - 1 - c; end
    return {8'(r) ^ 8'h30, 8'(c) ^ 8'h0C, b[7:0]};
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mp_addr[0] <= (mem_req_valid && mem_req_ready) ? mem_req_addr : 32'h0;
    for (int i = 1; i < RD_LAT; i++) mp_addr[i] <= mp_addr[i-1];
  end
  assign mem_rdata = mem_word(mp_addr[RD_LAT-1]);

  always @(negedge clk) mem_req_ready <= !(stall_on && (cyc % 7 == 3));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic idx, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic read_reg(input logic idx, output logic [31:0] d);
    @(negedge clk);
    reg_idx = idx;
    #1 d = reg_rdata;
  endtask

  task automatic wait_vs_fall();
    logic prev;
    @(negedge clk);
    prev = pix_vsync_n;
    forever begin
      @(negedge clk);
      if (prev && !pix_vsync_n) break;
      prev = pix_vsync_n;
    end
  endtask

  // Checks one displayed frame, optionally writing a new base partway in.
  task automatic capture(input logic [10:0] b, input logic rot, input logic en,
                         input bit mid, input logic [10:0] nb, input string tag);
    int p = 0, bad = 0, reqs = 0, guard = 0;
    logic [23:0] got, exp, fgot = '0, fexp = '0;
    wait_vs_fall();
    while (p < V_ACT * H_ACT && guard < 2 * FRAME) begin
      @(negedge clk);
      guard++;
      if (reg_we) reg_we = 1'b0;
      if (mem_req_valid) reqs++;
      if (pix_de) begin
        got = {pix_red, pix_green, pix_blue};
        exp = en ? exp_pix(b, rot, p) : 24'h0;
        if (got !== exp) begin
          if (bad == 0) begin fgot = got; fexp = exp; end
          bad++;
        end
        p++;
        if (mid && p == 10) begin
          reg_we = 1'b1; reg_idx = 1'b0; reg_wdata = {nb, 21'h0};
        end
      end
    end
    check(bad == 0, {tag, " pixels"}, 32'(fgot), 32'(fexp));
    check(p == V_ACT * H_ACT, "R4 data-enable count", 32'(p), 32'(V_ACT * H_ACT));
    if (!en) check(reqs == 0, "R8 no fetch while off", 32'(reqs), 32'h0);
  endtask

  initial begin
    #(WD_CYC * 20);
    fails++; tests++;
    $display("FAIL watchdog actual=%0d expected=<%0d cycles", WD_CYC, WD_CYC);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; reg_we = 1'b0; reg_idx = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: state held in reset
    check(pix_de == 1'b0, "R1 de in reset", 32'(pix_de), 32'h0);
    check(pix_hsync_n && pix_vsync_n, "R1 syncs in reset", {30'h0, pix_hsync_n, pix_vsync_n}, 32'h3);
    check({pix_red, pix_green, pix_blue} == 24'h0, "R1 colour in reset",
          {8'h0, pix_red, pix_green, pix_blue}, 32'h0);
    check(mem_req_valid == 1'b0, "R1 no request in reset", 32'(mem_req_valid), 32'h0);
    read_reg(1'b0, rd); check(rd == 32'h0, "R1 base reg reset", rd, 32'h0);
    read_reg(1'b1, rd); check(rd == 32'h0, "R1 control reg reset", rd, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R3/R4: raster totals over one whole frame
    begin
      int hs = 0, vs = 0, de = 0, run = 0, maxrun = 0;
      repeat (5) @(negedge clk);
      for (int i = 0; i < FRAME; i++) begin
        @(negedge clk);
        if (!pix_hsync_n) begin hs++; run++; if (run > maxrun) maxrun = run; end
        else run = 0;
        if (!pix_vsync_n) vs++;
        if (pix_de) de++;
      end
      check(hs == V_TOT * HSW, "R3 hsync low clocks", 32'(hs), 32'(V_TOT * HSW));
      check(maxrun == HSW, "R3 hsync pulse width", 32'(maxrun), 32'(HSW));
      check(vs == VSW * H_TOT, "R3 vsync low clocks", 32'(vs), 32'(VSW * H_TOT));
      check(de == V_ACT * H_ACT, "R4 de clocks per frame (off)", 32'(de), 32'(V_ACT * H_ACT));
    end

    // Table walk: R2 readback, R5/R6/R7 picture, R8 off, R10 stalls
    for (int v = 0; v < NVEC; v++) begin
      logic [10:0] b = VEC[v][13:3];
      logic [1:0]  c = VEC[v][2:1];
      string tag;
      stall_on = VEC[v][0];
      write_reg(1'b0, {b, 21'h1FFFFF});
      write_reg(1'b1, {30'h3FFFFFFF, c});
      read_reg(1'b0, rd); check(rd == {b, 21'h0}, "R2 base readback", rd, {b, 21'h0});
      read_reg(1'b1, rd); check(rd == {30'h0, c}, "R2 control readback", rd, {30'h0, c});
      if (!c[0])          tag = "R8 blank";
      else if (stall_on)  tag = c[1] ? "R10 R7 stalled rotated" : "R10 R5 stalled";
      else                tag = c[1] ? "R7 R6 rotated" : "R5 R6 normal";
      capture(b, c[1], c[0], 1'b0, 11'h0, tag);
    end
    stall_on = 1'b0;

    // R9: base written mid-frame waits for the next frame
    write_reg(1'b0, {11'h123, 21'h0});
    write_reg(1'b1, 32'h1);
    capture(11'h123, 1'b0, 1'b1, 1'b1, 11'h456, "R9 old base kept mid-frame");
    capture(11'h456, 1'b0, 1'b1, 1'b0, 11'h0, "R9 new base next frame");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule